// File: doc/BRIEF.md
# SMBus Control-Register Slave

This block is a two-wire serial slave that exposes eight 8-bit control registers to a bus master. It samples the clock and data lines with the system clock, removes short glitches, and detects start, repeated start and stop conditions. After a matching address, a command byte selects the access mode. With its top bit set, the command addresses one register by the offset in its low seven bits. With its top bit clear, the command opens a block transfer that always begins at register 0. A block transfer carries a byte count: the master sends it on a write, and the slave returns it first on a read.

The data line is open drain. The block never drives it high. It raises `sda_oe_o` to pull the line low, both for acknowledge slots and for the zero bits of read data. The register contents are presented continuously on a flat parallel vector. Two of the bits come from strap inputs and one whole register comes from an identification input. Neither can be written.

The controller is a single state machine with these states. IDLE waits for a start. ADDR shifts in the address byte and ADDR_ACK acknowledges it. CMD takes the command and CMD_ACK acknowledges it. CNT takes the block count and CNT_ACK acknowledges it. WDAT takes one write byte and WDAT_ACK acknowledges it. RDAT shifts out one read byte and RDAT_ACK samples the master's answer. HOLD ignores the bus until the next start or stop.

The transitions are as follows. A start in any state goes to ADDR, and a stop in any state goes to IDLE. ADDR goes to ADDR_ACK on a match and to HOLD otherwise. ADDR_ACK goes to CMD for a write or to RDAT for a read. CMD goes to CMD_ACK. CMD_ACK goes to CNT for a block command or to WDAT for a byte command. CNT goes to CNT_ACK, and CNT_ACK goes to WDAT. WDAT goes to WDAT_ACK when the byte is accepted and to HOLD when it is refused. WDAT_ACK returns to WDAT. RDAT goes to RDAT_ACK. RDAT_ACK returns to RDAT on a master acknowledge during a block read, and goes to HOLD otherwise.

Top module: `smb_regbank`

## Requirements
- R1: The slave acknowledges only the 7-bit address 69h (D2h on a write, D3h on a read). Any other address is left unacknowledged and has no effect on the registers.
- R2: After reset the registers read: reg0 = 4Ch with bits 1:0 taken from the straps, reg1 = 7Fh, reg2 = 00h, reg3 = FFh, reg4 = 47h, reg5 = DFh, reg6 = 03h, reg7 = the ID input.
- R3: A byte write uses a command with bit 7 = 1 and the register offset in bits 6:0, followed by one data byte. The slave acknowledges the command and the data, and the addressed register takes the value.
- R4: A byte read is a byte command, then a repeated start with the read address. The slave returns one data byte, most significant bit first, and releases the data line after the master's acknowledge so that a stop can follow.
- R5: A block write uses command 00h, then a count, then data bytes stored from register 0 upward. The first count data bytes are acknowledged. The first byte past the count is not acknowledged and is dropped.
- R6: A block read (command 00h, repeated start, read address) first returns the count 08h, then register 0 upward. It goes on while the master acknowledges and ends at the master's non-acknowledge.
- R7: Register 7 always equals the ID input, and register 0 bits 1:0 always equal the straps. Writes never change either.
- R8: A byte write to an offset above 7 is acknowledged and discarded. A byte read of such an offset returns 00h.
- R9: A stop after any complete byte ends the transfer, releases the data line, and keeps every byte already written.
- R10: The data line is pulled low only in acknowledge slots and for zero read-data bits. It is never pulled low while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset, loads register defaults |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 = pull the data line low |
| strap_i | input | 2 | Strap values shown in register 0 bits 1:0 |
| id_i | input | 8 | Identification byte shown as register 7 |
| regs_o | output | 64 | All registers, register k in bits 8k+7:8k |

## Verification
Byte writes and byte reads are swept over every offset from 0 to 9, each with a distinct data value derived from the offset. This separates the writable registers from the read-only register 7, the strap bits of register 0, and the out-of-range offsets. Block writes are tried three ways: with a full count, with a count shorter than the bytes sent, and cut short by an early stop. Together these separate the count bound from the stop handling. A block read checks the leading count and the order of the data. A wrong address checks for the missing acknowledge and confirms that the registers are left untouched.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_CNT,
        ST_CNT_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RDAT_ACK,
        ST_HOLD
    } smb_state_e;

    function automatic logic [7:0] reg_default(input int idx);
        logic [7:0] v;
        case (idx)
            0:       v = 8'h4C;
            1:       v = 8'h7F;
            2:       v = 8'h00;
            3:       v = 8'hFF;
            4:       v = 8'h47;
            5:       v = 8'hDF;
            6:       v = 8'h03;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/smb_glitch_filt.sv
module smb_glitch_filt #(
    parameter int LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [1:0]     sync_q;
    logic [LEN-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            hist_q <= '1;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], din};
            hist_q <= {hist_q[LEN-2:0], sync_q[1]};
            if (&hist_q)
                dout <= 1'b1;
            else if (~|hist_q)
                dout <= 1'b0;
        end
    end
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_f;
    logic scl_q;
    logic sda_q;

    smb_glitch_filt #(.LEN(FILT_LEN)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_f)
    );
    smb_glitch_filt #(.LEN(FILT_LEN)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_f)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise = scl_f & ~scl_q;
    assign scl_fall = ~scl_f & scl_q;
    // data edges only count as conditions while the clock stays high
    assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/smb_ctrl_regs.sv
module smb_ctrl_regs
    import smb_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [6:0]        waddr,
    input  logic [7:0]        wdata,
    input  logic [6:0]        raddr,
    output logic [7:0]        rdata,
    input  logic [1:0]        strap_i,
    input  logic [7:0]        id_i,
    output logic [NREG*8-1:0] regs_o
);
    localparam int         AW     = $clog2(NREG);
    localparam logic [6:0] NREG7  = 7'(NREG);
    localparam logic [6:0] ID_IDX = 7'(NREG - 1);

    logic [7:0] mem_q [NREG];
    logic [7:0] eff   [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++)
                mem_q[i] <= reg_default(i);
        end else if (we && (waddr < NREG7) && (waddr != ID_IDX)) begin
            mem_q[waddr[AW-1:0]] <= wdata;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_view
        if (g == 0) begin : g_strap
            assign eff[g] = {mem_q[g][7:2], strap_i};
        end else if (g == NREG - 1) begin : g_id
            assign eff[g] = id_i;
        end else begin : g_plain
            assign eff[g] = mem_q[g];
        end
        assign regs_o[g*8 +: 8] = eff[g];
    end

    assign rdata = (raddr < NREG7) ? eff[raddr[AW-1:0]] : 8'h00;
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
    import smb_pkg::*;
#(
    parameter int         NREG     = 8,
    parameter int         FILT_LEN = 3,
    parameter logic [6:0] SLV_ADDR = 7'h69
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [1:0]        strap_i,
    input  logic [7:0]        id_i,
    output logic [NREG*8-1:0] regs_o
);
    localparam logic [7:0] COUNT_BYTE = 8'(NREG);

    smb_state_e state, nxt;

    logic       sda_f, scl_rise, scl_fall, start_ev, stop_ev;
    logic [3:0] bitcnt;
    logic [7:0] sr, tx, remain;
    logic [6:0] ptr, raddr, waddr;
    logic [7:0] wdata, rdata, load_byte;
    logic       rw, blk, cnt_pend, nack, we;
    logic       bc8, bc1, addr_hit, wr_ok, rx_state;

    smb_bus_events #(.FILT_LEN(FILT_LEN)) u_events (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_f(sda_f), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    smb_ctrl_regs #(.NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rdata), .strap_i(strap_i), .id_i(id_i),
        .regs_o(regs_o)
    );

    assign bc8      = (bitcnt == 4'd8);
    assign bc1      = (bitcnt == 4'd1);
    assign addr_hit = (sr[7:1] == SLV_ADDR);
    assign wr_ok    = !blk || (remain != 8'd0);
    assign rx_state = (state == ST_ADDR) || (state == ST_CMD) ||
                      (state == ST_CNT)  || (state == ST_WDAT);
    // a data byte already sent advances the pointer before the next fetch
    assign raddr     = (state == ST_RDAT_ACK && !cnt_pend) ? ptr + 7'd1 : ptr;
    assign load_byte = (state == ST_ADDR_ACK && cnt_pend) ? COUNT_BYTE : rdata;

    always_comb begin
        nxt = state;
        if (stop_ev) begin
            nxt = ST_IDLE;
        end else if (start_ev) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE, ST_HOLD: nxt = state;
                ST_ADDR:     if (scl_fall && bc8) nxt = addr_hit ? ST_ADDR_ACK : ST_HOLD;
                ST_ADDR_ACK: if (scl_fall && bc1) nxt = rw ? ST_RDAT : ST_CMD;
                ST_CMD:      if (scl_fall && bc8) nxt = ST_CMD_ACK;
                ST_CMD_ACK:  if (scl_fall && bc1) nxt = blk ? ST_CNT : ST_WDAT;
                ST_CNT:      if (scl_fall && bc8) nxt = ST_CNT_ACK;
                ST_CNT_ACK:  if (scl_fall && bc1) nxt = ST_WDAT;
                ST_WDAT:     if (scl_fall && bc8) nxt = wr_ok ? ST_WDAT_ACK : ST_HOLD;
                ST_WDAT_ACK: if (scl_fall && bc1) nxt = ST_WDAT;
                ST_RDAT:     if (scl_fall && bc8) nxt = ST_RDAT_ACK;
                ST_RDAT_ACK: if (scl_fall && bc1) nxt = (nack || !blk) ? ST_HOLD : ST_RDAT;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe_o <= 1'b0;
            bitcnt   <= 4'd0;
            sr       <= 8'h00;
            tx       <= 8'h00;
            remain   <= 8'h00;
            ptr      <= 7'd0;
            rw       <= 1'b0;
            blk      <= 1'b0;
            cnt_pend <= 1'b0;
            nack     <= 1'b0;
            we       <= 1'b0;
            waddr    <= 7'd0;
            wdata    <= 8'h00;
        end else begin
            we <= 1'b0;
            if (stop_ev || start_ev) begin
                sda_oe_o <= 1'b0;
                bitcnt   <= 4'd0;
            end else begin
                if (scl_rise && state != ST_IDLE && state != ST_HOLD) begin
                    bitcnt <= bitcnt + 4'd1;
                    if (rx_state)
                        sr <= {sr[6:0], sda_f};
                    if (state == ST_RDAT_ACK)
                        nack <= sda_f;
                end
                if (scl_fall) begin
                    unique case (state)
                        ST_ADDR: if (bc8) begin
                            bitcnt <= 4'd0;
                            if (addr_hit) begin
                                sda_oe_o <= 1'b1;
                                rw       <= sr[0];
                            end
                        end
                        ST_ADDR_ACK: if (bc1) begin
                            bitcnt <= 4'd0;
                            if (rw) begin
                                tx       <= load_byte;
                                sda_oe_o <= ~load_byte[7];
                            end else begin
                                sda_oe_o <= 1'b0;
                            end
                        end
                        ST_CMD: if (bc8) begin
                            bitcnt   <= 4'd0;
                            sda_oe_o <= 1'b1;
                            blk      <= ~sr[7];
                            cnt_pend <= ~sr[7];
                            ptr      <= sr[7] ? sr[6:0] : 7'd0;
                        end
                        ST_CNT: if (bc8) begin
                            bitcnt   <= 4'd0;
                            sda_oe_o <= 1'b1;
                            remain   <= sr;
                        end
                        ST_WDAT: if (bc8) begin
                            bitcnt <= 4'd0;
                            if (wr_ok) begin
                                sda_oe_o <= 1'b1;
                                we       <= 1'b1;
                                waddr    <= ptr;
                                wdata    <= sr;
                                ptr      <= ptr + 7'd1;
                                if (blk) remain <= remain - 8'd1;
                            end
                        end
                        ST_CMD_ACK, ST_CNT_ACK, ST_WDAT_ACK: if (bc1) begin
                            bitcnt   <= 4'd0;
                            sda_oe_o <= 1'b0;
                        end
                        ST_RDAT: begin
                            if (bc8) begin
                                bitcnt   <= 4'd0;
                                sda_oe_o <= 1'b0;
                            end else begin
                                tx       <= {tx[6:0], 1'b0};
                                sda_oe_o <= ~tx[6];
                            end
                        end
                        ST_RDAT_ACK: if (bc1) begin
                            bitcnt <= 4'd0;
                            if (cnt_pend) cnt_pend <= 1'b0;
                            else          ptr      <= ptr + 7'd1;
                            if (!nack && blk) begin
                                tx       <= load_byte;
                                sda_oe_o <= ~load_byte[7];
                            end else begin
                                sda_oe_o <= 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/smb_regbank_chk.sv
module smb_regbank_chk
    import smb_pkg::*;
#(
    parameter int NREG = 8
) (
    input logic              clk,
    input logic              rst_n,
    input smb_state_e        state,
    input logic              sda_oe_o,
    input logic              start_ev,
    input logic              stop_ev,
    input logic              we,
    input logic [1:0]        strap_i,
    input logic [7:0]        id_i,
    input logic [NREG*8-1:0] regs_o
);
    p_start_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_ADDR));

    p_hold_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> !sda_oe_o);

    p_id_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        regs_o[NREG*8-1 -: 8] == id_i);

    p_strap_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        regs_o[1:0] == strap_i);

    p_we_after_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (state == ST_WDAT_ACK));

    p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (!sda_oe_o && state == ST_IDLE));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe_o);
endmodule

bind smb_regbank smb_regbank_chk #(.NREG(NREG)) chk_i (
    .clk(clk), .rst_n(rst_n), .state(state), .sda_oe_o(sda_oe_o),
    .start_ev(start_ev), .stop_ev(stop_ev), .we(we),
    .strap_i(strap_i), .id_i(id_i), .regs_o(regs_o)
);

// File: tb/smb_regbank_tb_top.sv
module smb_regbank_tb_top;
    localparam logic [1:0] STRAP = 2'b10;
    localparam logic [7:0] IDB   = 8'h48;
    localparam logic [7:0] AW_WR = 8'hD2;
    localparam logic [7:0] AW_RD = 8'hD3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [63:0] regs;
    wire         sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] mdl [8];

    always #2 clk = ~clk;

    smb_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .strap_i(STRAP), .id_i(IDB), .regs_o(regs)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input int off);
        if (off >= 8) return 8'h00;
        if (off == 0) return {mdl[0][7:2], STRAP};
        if (off == 7) return IDB;
        return mdl[off];
    endfunction

    function automatic logic [7:0] pat(input int a, input int b);
        return 8'((a * 59) ^ (b * 90) ^ 195);
    endfunction

    task automatic bus_start;
        wt(8); sda_m = 1'b1; wt(8); scl = 1'b1; wt(16); sda_m = 1'b0; wt(16); scl = 1'b0;
    endtask

    task automatic bus_stop;
        wt(8); sda_m = 1'b0; wt(8); scl = 1'b1; wt(16); sda_m = 1'b1; wt(16);
    endtask

    task automatic clk_bit(input logic v, output logic s);
        wt(8); sda_m = v; wt(8); scl = 1'b1; wt(8); s = sda_line; wt(8); scl = 1'b0;
    endtask

    task automatic tx_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic rx_byte(input logic mack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(~mack, s);
    endtask

    task automatic byte_write(input int off, input logic [7:0] d, output logic [2:0] acks);
        bus_start;
        tx_byte(AW_WR, acks[2]);
        tx_byte(8'h80 | 8'(off), acks[1]);
        tx_byte(d, acks[0]);
        bus_stop;
    endtask

    task automatic byte_read(input int off, output logic [7:0] d, output logic [2:0] acks);
        bus_start;
        tx_byte(AW_WR, acks[2]);
        tx_byte(8'h80 | 8'(off), acks[1]);
        bus_start;
        tx_byte(AW_RD, acks[0]);
        rx_byte(1'b1, d);
        bus_stop;
    endtask

    initial begin
        logic [2:0] a3;
        logic       ak;
        logic [7:0] d;
        for (int k = 0; k < 8; k++) mdl[k] = 8'h00;
        mdl[0] = 8'h4C; mdl[1] = 8'h7F; mdl[3] = 8'hFF;
        mdl[4] = 8'h47; mdl[5] = 8'hDF; mdl[6] = 8'h03;
        wt(10);
        rst_n = 1'b1;
        wt(10);

        // R2: reset values seen at the parallel outputs
        for (int k = 0; k < 8; k++) chk8("R2 reset value", regs[k*8 +: 8], exp_rd(k));
        chk8("R10 idle release", 8'(sda_oe), 8'h00);

        // R3/R8/R7: byte write sweep over offsets 0..9
        for (int off = 0; off < 10; off++) begin
            d = pat(off, 1);
            byte_write(off, d, a3);
            chk8("R3 byte write acks", 8'(a3), 8'h07);
            if (off < 7) mdl[off] = d;
        end
        for (int k = 0; k < 8; k++) chk8("R3 R7 parallel view", regs[k*8 +: 8], exp_rd(k));

        // R4/R8: byte read sweep
        for (int off = 0; off < 10; off++) begin
            byte_read(off, d, a3);
            chk8("R4 byte read acks", 8'(a3), 8'h07);
            chk8(off >= 8 ? "R8 out of range read" : "R4 byte read data", d, exp_rd(off));
        end

        // R1: wrong address left unacknowledged, no effect
        bus_start;
        tx_byte(8'hD4, ak);
        chk8("R1 wrong address nack", 8'(ak), 8'h00);
        tx_byte(8'h82, ak);
        tx_byte(8'h11, ak);
        bus_stop;
        chk8("R1 no effect", regs[23:16], exp_rd(2));

        // R5: full block write, count 8
        bus_start;
        tx_byte(AW_WR, ak);
        tx_byte(8'h00, ak);
        chk8("R5 block cmd ack", 8'(ak), 8'h01);
        tx_byte(8'h08, ak);
        chk8("R5 count ack", 8'(ak), 8'h01);
        for (int k = 0; k < 8; k++) begin
            d = pat(k, 2);
            tx_byte(d, ak);
            chk8("R5 block data ack", 8'(ak), 8'h01);
            if (k < 7) mdl[k] = d;
        end
        bus_stop;
        for (int k = 0; k < 8; k++) chk8("R5 R7 block stored", regs[k*8 +: 8], exp_rd(k));

        // R6: block read, count first then registers 0 upward
        bus_start;
        tx_byte(AW_WR, ak);
        tx_byte(8'h00, ak);
        bus_start;
        tx_byte(AW_RD, ak);
        chk8("R6 read address ack", 8'(ak), 8'h01);
        rx_byte(1'b1, d);
        chk8("R6 count byte", d, 8'h08);
        for (int k = 0; k < 8; k++) begin
            rx_byte(k != 7, d);
            chk8("R6 block read data", d, exp_rd(k));
        end
        bus_stop;
        chk8("R6 released after nack", 8'(sda_oe), 8'h00);

        // R5: count 3, fourth byte refused and dropped
        bus_start;
        tx_byte(AW_WR, ak);
        tx_byte(8'h00, ak);
        tx_byte(8'h03, ak);
        for (int k = 0; k < 4; k++) begin
            d = pat(k, 3);
            tx_byte(d, ak);
            chk8("R5 count bound ack", 8'(ak), (k < 3) ? 8'h01 : 8'h00);
            if (k < 3) mdl[k] = d;
        end
        bus_stop;
        for (int k = 0; k < 5; k++) chk8("R5 count bound store", regs[k*8 +: 8], exp_rd(k));

        // R9: stop after two bytes of a count-6 block write
        bus_start;
        tx_byte(AW_WR, ak);
        tx_byte(8'h00, ak);
        tx_byte(8'h06, ak);
        for (int k = 0; k < 2; k++) begin
            d = pat(k, 4);
            tx_byte(d, ak);
            mdl[k] = d;
        end
        bus_stop;
        chk8("R9 line released", 8'(sda_oe), 8'h00);
        for (int k = 0; k < 8; k++) chk8("R9 partial block kept", regs[k*8 +: 8], exp_rd(k));

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule